// File: doc/BRIEF.md
# Clock Correction Failure Error Monitor

This block watches a time-triggered bus controller for lost clock rate correction. The controller gives a strobe at the end of every odd (double) communication cycle, together with a flag that says whether a usable pair of sync frames let the rate correction run. Each odd cycle that ends without a correction advances a saturating failure count. An odd cycle that ends with a successful correction clears the count.

The count is compared against two limits that the host programs: a passive limit and a fatal limit. The error level lives in a three-state machine with the states GREEN, YELLOW and RED. These are the transitions:

- MISS_PASSIVE goes from GREEN to YELLOW.
- MISS_FATAL goes from GREEN or YELLOW to RED.
- CFG_RESTART goes from YELLOW or RED back to GREEN when the controller re-enters its configuration state.

Every escalation sets one interrupt-pending flag. The host reads that flag and clears it through a small register port. The same port holds the two limits, which can be written only while the controller is being configured.

Top module: `ccorr_err_mon`

## Requirements
- R1: Outside the configuration state, each cycle with `cyc_odd_end`=1 and `corr_ok`=0 adds one to the failure count. The count reads back in bits 14:0 of offset 0xE4.
- R2: An odd-cycle end with `corr_ok`=1 clears the count to 0 and leaves the error level unchanged. A cycle without `cyc_odd_end` leaves the count unchanged whatever `corr_ok` is.
- R3: When a counted miss makes the new count equal the passive limit (offset 0xD8) while the level is GREEN, the level becomes YELLOW (code 1). YELLOW stays until the configuration state is entered again.
- R4: When a counted miss makes the new count equal the fatal limit (offset 0xCC), the level becomes RED (code 2), from GREEN or from YELLOW. RED wins when both limits match in the same cycle. RED is sticky until the configuration state.
- R5: A write to a limit offset takes effect only while `cfg_state`=1 and is ignored otherwise. Each limit holds a 16-bit value that reads back unchanged, so every value from 1 to 32767 is supported.
- R6: While `cfg_state`=1 the level is forced to GREEN (code 0), the count is forced to 0, and the odd-cycle strobes are ignored.
- R7: Each transition into YELLOW or into RED sets the pending flag. The flag is visible on `irq` and in bit 2 of offset 0xE0. A write to 0xE0 with bit 2 = 1 clears the flag, but an escalation in the same cycle keeps it set.
- R8: The failure count saturates at 32767. Further misses leave it at 32767.
- R9: After reset the level is GREEN (code 0), the flag is 0, the count is 0 and both limits read 0. A limit of 0 never matches. Offset 0xE0 bits 1:0 give the level code, and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_state | input | 1 | Controller is in its configuration state |
| cyc_odd_end | input | 1 | One-cycle strobe at the end of an odd communication cycle |
| corr_ok | input | 1 | Rate correction succeeded in the cycle ending now (qualified by `cyc_odd_end`) |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register offset for reads and writes |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational from `reg_addr` |
| err_level | output | 2 | Error level: 0 green, 1 yellow, 2 red |
| irq | output | 1 | Interrupt-pending flag |

## Verification
Two functions of this block can land on the same clock edge:

- An escalation sets the pending flag.
- A host write of 1 to bit 2 of 0xE0 clears that flag.

The bench provokes this in a directed case: equal passive and fatal limits make a miss jump straight from GREEN to RED on the edge that also carries the clear write. The random phase mixes clear writes with misses, so the collision also happens by chance. The bench model applies set-over-clear, so any cycle where the flag drops while the level rose is reported as a mismatch on `irq`.

// File: rtl/ccmon_pkg.sv
package ccmon_pkg;

    typedef enum logic [1:0] {
        LVL_GREEN  = 2'd0,
        LVL_YELLOW = 2'd1,
        LVL_RED    = 2'd2
    } lvl_e;

    localparam int NUM_LIM      = 2;
    localparam int LIM_PAS      = 0;
    localparam int LIM_FAT      = 1;
    localparam int STAT_IRQ_BIT = 2;

endpackage

// File: rtl/ccmon_limit_regs.sv
module ccmon_limit_regs
    import ccmon_pkg::*;
#(
    parameter int              REG_W    = 16,
    parameter int              ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] ADDR_PAS = 8'hD8,
    parameter logic [ADDR_W-1:0] ADDR_FAT = 8'hCC
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cfg_state,
    input  logic                           reg_wr,
    input  logic [ADDR_W-1:0]              reg_addr,
    input  logic [REG_W-1:0]               reg_wdata,
    output logic [NUM_LIM-1:0][REG_W-1:0]  lim_q
);

    localparam logic [ADDR_W-1:0] SLOT_ADDR [NUM_LIM] = '{ADDR_PAS, ADDR_FAT};

    for (genvar g = 0; g < NUM_LIM; g++) begin : g_lim
        logic slot_we;
        assign slot_we = cfg_state && reg_wr && (reg_addr == SLOT_ADDR[g]);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lim_q[g] <= '0;
            end else if (slot_we) begin
                lim_q[g] <= reg_wdata;
            end
        end
    end

endmodule

// File: rtl/ccmon_fail_cnt.sv
module ccmon_fail_cnt #(
    parameter int CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             miss,
    input  logic             hit,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_inc
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    // Saturating successor of the present count
    always_comb begin
        if (cnt_q == CNT_MAX) begin
            cnt_inc = cnt_q;
        end else begin
            cnt_inc = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr || hit) begin
            cnt_q <= '0;
        end else if (miss) begin
            cnt_q <= cnt_inc;
        end
    end

endmodule

// File: rtl/ccmon_level_fsm.sv
module ccmon_level_fsm
    import ccmon_pkg::*;
#(
    parameter int CNT_W = 15,
    parameter int REG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_state,
    input  logic             miss,
    input  logic [CNT_W-1:0] cnt_inc,
    input  logic [REG_W-1:0] pas_lim,
    input  logic [REG_W-1:0] fat_lim,
    input  logic             irq_clr,
    output logic [1:0]       level_o,
    output logic             irq_o
);

    lvl_e state_q, state_d;
    logic hit_pas, hit_fat;
    logic escalate;

    assign hit_pas = (REG_W'(cnt_inc) == pas_lim);
    assign hit_fat = (REG_W'(cnt_inc) == fat_lim);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (cfg_state) begin
            state_d = LVL_GREEN;                      // CFG_RESTART
        end else if (miss) begin
            unique case (state_q)
                LVL_GREEN: begin
                    if (hit_fat) begin
                        state_d = LVL_RED;            // MISS_FATAL
                    end else if (hit_pas) begin
                        state_d = LVL_YELLOW;         // MISS_PASSIVE
                    end
                end
                LVL_YELLOW: begin
                    if (hit_fat) begin
                        state_d = LVL_RED;            // MISS_FATAL
                    end
                end
                LVL_RED: begin
                    state_d = LVL_RED;
                end
                default: begin
                    state_d = LVL_GREEN;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LVL_GREEN;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs
    always_comb begin
        level_o  = state_q;
        escalate = (state_d != state_q) && (state_d != LVL_GREEN);
    end

    // Pending flag, set has priority over clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_o <= 1'b0;
        end else if (escalate) begin
            irq_o <= 1'b1;
        end else if (irq_clr) begin
            irq_o <= 1'b0;
        end
    end

endmodule

// File: rtl/ccorr_err_mon.sv
module ccorr_err_mon
    import ccmon_pkg::*;
#(
    parameter int                REG_W     = 16,
    parameter int                CNT_W     = 15,
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] ADDR_FAT  = 8'hCC,
    parameter logic [ADDR_W-1:0] ADDR_PAS  = 8'hD8,
    parameter logic [ADDR_W-1:0] ADDR_STAT = 8'hE0,
    parameter logic [ADDR_W-1:0] ADDR_CNT  = 8'hE4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_state,
    input  logic              cyc_odd_end,
    input  logic              corr_ok,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic [1:0]        err_level,
    output logic              irq
);

    logic [NUM_LIM-1:0][REG_W-1:0] lim_q;
    logic [CNT_W-1:0]              cnt_q;
    logic [CNT_W-1:0]              cnt_inc;
    logic                          miss;
    logic                          hit;
    logic                          irq_clr;

    assign miss    = cyc_odd_end && !corr_ok && !cfg_state;
    assign hit     = cyc_odd_end &&  corr_ok && !cfg_state;
    assign irq_clr = reg_wr && (reg_addr == ADDR_STAT) && reg_wdata[STAT_IRQ_BIT];

    ccmon_limit_regs #(
        .REG_W    (REG_W),
        .ADDR_W   (ADDR_W),
        .ADDR_PAS (ADDR_PAS),
        .ADDR_FAT (ADDR_FAT)
    ) u_limits (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_state (cfg_state),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .lim_q     (lim_q)
    );

    ccmon_fail_cnt #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (cfg_state),
        .miss    (miss),
        .hit     (hit),
        .cnt_q   (cnt_q),
        .cnt_inc (cnt_inc)
    );

    ccmon_level_fsm #(
        .CNT_W (CNT_W),
        .REG_W (REG_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_state (cfg_state),
        .miss      (miss),
        .cnt_inc   (cnt_inc),
        .pas_lim   (lim_q[LIM_PAS]),
        .fat_lim   (lim_q[LIM_FAT]),
        .irq_clr   (irq_clr),
        .level_o   (err_level),
        .irq_o     (irq)
    );

    // Read multiplexer
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_FAT:  reg_rdata = lim_q[LIM_FAT];
            ADDR_PAS:  reg_rdata = lim_q[LIM_PAS];
            ADDR_STAT: begin
                reg_rdata[1:0]          = err_level;
                reg_rdata[STAT_IRQ_BIT] = irq;
            end
            ADDR_CNT:  reg_rdata = REG_W'(cnt_q);
            default:   reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/ccmon_checker.sv
module ccmon_checker #(
    parameter int CNT_W = 15,
    parameter int REG_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_state,
    input logic             cyc_odd_end,
    input logic             corr_ok,
    input logic             reg_wr,
    input logic [1:0]       err_level,
    input logic             irq,
    input logic [CNT_W-1:0] cnt,
    input logic [REG_W-1:0] pas_lim,
    input logic [REG_W-1:0] fat_lim
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_odd_end && !corr_ok && !cfg_state && cnt != CNT_MAX) |=> cnt == CNT_W'($past(cnt) + 1'b1)); // R1

    AST_CORR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_odd_end && corr_ok) |=> cnt == '0); // R2

    AST_YELLOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (err_level == 2'd1 && !cfg_state) |=> err_level != 2'd0); // R3

    AST_RED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err_level == 2'd2 && !cfg_state) |=> err_level == 2'd2); // R4

    AST_LIMIT_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !cfg_state) |=> ($stable(pas_lim) && $stable(fat_lim))); // R5

    AST_CFG_GREEN: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_state |=> (err_level == 2'd0 && cnt == '0)); // R6

    AST_ESC_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(err_level) && err_level != 2'd0) |-> irq); // R7

    AST_CNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CNT_MAX && cyc_odd_end && !corr_ok && !cfg_state) |=> cnt == CNT_MAX); // R8

endmodule

bind ccorr_err_mon ccmon_checker #(
    .CNT_W (CNT_W),
    .REG_W (REG_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_state   (cfg_state),
    .cyc_odd_end (cyc_odd_end),
    .corr_ok     (corr_ok),
    .reg_wr      (reg_wr),
    .err_level   (err_level),
    .irq         (irq),
    .cnt         (cnt_q),
    .pas_lim     (lim_q[0]),
    .fat_lim     (lim_q[1])
);

// File: tb/test_ccorr_err_mon.sv
`timescale 1ns/1ps
module test_ccorr_err_mon;

    localparam logic [7:0] A_FAT  = 8'hCC;
    localparam logic [7:0] A_PAS  = 8'hD8;
    localparam logic [7:0] A_STAT = 8'hE0;
    localparam logic [7:0] A_CNT  = 8'hE4;
    localparam int         CMAX   = 32767;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_state = 1'b0;
    logic        cyc_odd_end = 1'b0;
    logic        corr_ok = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [15:0] reg_wdata = 16'h0000;
    logic [15:0] reg_rdata;
    logic [1:0]  err_level;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // model state
    int          m_cnt = 0;
    int          m_lvl = 0;
    bit          m_irq = 1'b0;
    logic [15:0] m_pas = '0;
    logic [15:0] m_fat = '0;

    always #2.5 clk = ~clk;

    ccorr_err_mon i_ccorr_err_mon (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_state   (cfg_state),
        .cyc_odd_end (cyc_odd_end),
        .corr_ok     (corr_ok),
        .reg_wr      (reg_wr),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .err_level   (err_level),
        .irq         (irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // Expected behaviour from the requirements, one clock edge
    function automatic void model_edge(bit odd, bit ok, bit cfg, bit wr,
                                       logic [7:0] addr, logic [15:0] wd);
        bit esc = 1'b0;
        int nc;
        if (cfg) begin
            m_lvl = 0;
            m_cnt = 0;
            if (wr && addr == A_PAS) m_pas = wd;
            if (wr && addr == A_FAT) m_fat = wd;
        end else if (odd) begin
            if (ok) begin
                m_cnt = 0;
            end else begin
                nc = (m_cnt == CMAX) ? CMAX : m_cnt + 1;
                if (nc == int'(m_fat) && m_lvl != 2) begin
                    m_lvl = 2; esc = 1'b1;
                end else if (nc == int'(m_pas) && m_lvl == 0) begin
                    m_lvl = 1; esc = 1'b1;
                end
                m_cnt = nc;
            end
        end
        if (esc) m_irq = 1'b1;
        else if (wr && addr == A_STAT && wd[2]) m_irq = 1'b0;
    endfunction

    task automatic step(input bit odd, input bit ok, input bit cfg, input bit wr,
                        input logic [7:0] addr, input logic [15:0] wd);
        cfg_state   = cfg;
        cyc_odd_end = odd;
        corr_ok     = ok;
        reg_wr      = wr;
        reg_addr    = addr;
        reg_wdata   = wd;
        @(posedge clk);
        model_edge(odd, ok, cfg, wr, addr, wd);
        #1;
        reg_wr = 1'b0; cyc_odd_end = 1'b0; corr_ok = 1'b0;
        chk("R3 level", int'(err_level), m_lvl);
        chk("R7 irq", int'(irq), int'(m_irq));
        reg_addr = A_CNT;
        #0.5;
        chk("R1 count", int'(reg_rdata), m_cnt);
    endtask

    task automatic rd(input logic [7:0] addr, output int val);
        reg_addr = addr;
        #0.5;
        val = int'(reg_rdata);
    endtask

    task automatic miss(input int n);
        for (int i = 0; i < n; i++) step(1, 0, cfg_state, 0, 8'h00, 16'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        int v;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        // R9 reset state
        chk("R9 level", int'(err_level), 0);
        chk("R9 irq", int'(irq), 0);
        rd(A_CNT, v);  chk("R9 count", v, 0);
        rd(A_PAS, v);  chk("R9 passive", v, 0);
        rd(A_FAT, v);  chk("R9 fatal", v, 0);
        rd(8'h10, v);  chk("R9 unmapped", v, 0);
        // zero limits never match
        miss(3);
        chk("R9 zero limit", int'(err_level), 0);

        // R5 program limits in configuration
        step(0, 0, 1, 1, A_PAS, 16'd3);
        step(0, 0, 1, 1, A_FAT, 16'd5);
        rd(A_PAS, v); chk("R5 passive", v, 3);
        rd(A_FAT, v); chk("R5 fatal", v, 5);
        step(0, 0, 0, 1, A_PAS, 16'd9);
        step(0, 0, 0, 1, A_FAT, 16'd1);
        rd(A_PAS, v); chk("R5 passive locked", v, 3);
        rd(A_FAT, v); chk("R5 fatal locked", v, 5);

        // R1 / R2
        miss(2);
        step(0, 1, 0, 0, 8'h00, 16'h0);
        rd(A_CNT, v); chk("R2 ok without odd end", v, 2);
        step(1, 1, 0, 0, 8'h00, 16'h0);
        rd(A_CNT, v); chk("R2 cleared", v, 0);

        // R3 yellow, R7 irq and clear
        miss(3);
        chk("R3 yellow", int'(err_level), 1);
        chk("R7 irq yellow", int'(irq), 1);
        step(0, 0, 0, 1, A_STAT, 16'h0004);
        chk("R7 cleared", int'(irq), 0);
        step(1, 1, 0, 0, 8'h00, 16'h0);
        chk("R2 level kept", int'(err_level), 1);

        // R4 red, sticky
        miss(5);
        chk("R4 red", int'(err_level), 2);
        miss(2);
        step(1, 1, 0, 0, 8'h00, 16'h0);
        chk("R4 sticky", int'(err_level), 2);
        rd(A_STAT, v); chk("R9 status", v, 6);

        // R6 configuration restart, strobes ignored
        step(1, 0, 1, 0, 8'h00, 16'h0);
        step(1, 0, 1, 0, 8'h00, 16'h0);
        chk("R6 green", int'(err_level), 0);
        rd(A_CNT, v); chk("R6 count", v, 0);

        // Equal limits: direct red with clear write on the same edge
        step(0, 0, 1, 1, A_PAS, 16'd2);
        step(0, 0, 1, 1, A_FAT, 16'd2);
        step(0, 0, 0, 1, A_STAT, 16'h0004);
        miss(1);
        step(1, 0, 0, 1, A_STAT, 16'h0004);
        chk("R4 fatal priority", int'(err_level), 2);
        chk("R7 set beats clear", int'(irq), 1);

        // R8 saturation
        step(0, 0, 1, 1, A_FAT, 16'd32767);
        step(0, 0, 1, 1, A_PAS, 16'd32766);
        step(0, 0, 0, 1, A_STAT, 16'h0004);
        miss(32766);
        chk("R3 yellow high limit", int'(err_level), 1);
        step(0, 0, 0, 1, A_STAT, 16'h0004);
        miss(1);
        chk("R4 red at max", int'(err_level), 2);
        step(0, 0, 0, 1, A_STAT, 16'h0004);
        miss(3);
        rd(A_CNT, v); chk("R8 saturated", v, CMAX);
        chk("R7 no re-raise", int'(irq), 0);

        // Constrained random phase
        step(0, 0, 1, 0, 8'h00, 16'h0);
        for (int k = 0; k < 3000; k++) begin
            bit cfg, odd, ok, wr;
            logic [7:0]  ad;
            logic [15:0] wd;
            int sel;
            cfg = ($urandom_range(0, 39) == 0) ? 1'b1 : (cfg_state && $urandom_range(0, 2) != 0);
            odd = ($urandom_range(0, 2) == 0);
            ok  = ($urandom_range(0, 4) == 0);
            wr  = ($urandom_range(0, 5) == 0);
            sel = $urandom_range(0, 2);
            ad  = (sel == 0) ? A_PAS : (sel == 1) ? A_FAT : A_STAT;
            wd  = (sel == 2) ? 16'h0004 : 16'($urandom_range(1, 8));
            step(odd, ok, cfg, wr, ad, wd);
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule